// File: doc/BRIEF.md
# Strap-Addressed Two-Wire Control Target

This block is the control port of a tuner or demodulator chip. It sits on a two-wire serial bus (SCL and SDA, both open-drain) as a target device. Two board straps choose one of four 7-bit device addresses, so several such chips can share one bus. A write transfer first carries a register index, then data bytes. These bytes land in a small bank of configuration registers, and the index advances after each byte. The bank is presented on a parallel bus to the rest of the chip.

A read transfer returns a status byte built from live inputs of the demodulator. The byte also holds a sticky power-on flag, which tells the host that the chip has been reset since it last looked. The flag clears after the host has read a status byte. Both bus lines are synchronized and filtered in the system clock domain before START and STOP are detected.

Top module: `strap_i2c_target`

## Requirements
- R1: The device address is {1,0,0,A3,0,1,A0}, with A3 = `strap_a3` and A0 = NOT `strap_a0`, giving 0x43, 0x42, 0x4B or 0x4A. An address byte (address in bits 7:1, read flag in bit 0, 1 = read) that matches is acknowledged.
- R2: An address byte that does not match is not acknowledged. Until the next START, SDA stays released and later bytes leave the registers unchanged.
- R3: In a write, the first data byte loads the register pointer from its low log2(NUM_REGS) bits. Each following byte is stored in register[pointer], after which the pointer increments and wraps modulo NUM_REGS. Register i appears on `cfg_regs[8*i+7:8*i]`.
- R4: The target acknowledges a matched address and every write byte by holding SDA low through the ninth clock.
- R5: A read byte is, MSB to LSB: AFC-window flag, input-level flag, carrier flag, the 4-bit AFC field, and the power-on flag in bit 0.
- R6: The target keeps sending bytes while the host acknowledges. After a not-acknowledge it releases SDA and stays quiet until a new START.
- R7: The power-on flag reads 1 after reset. It clears once a read byte has been shifted out and its acknowledge clock has risen, and only a reset sets it again.
- R8: A START that arrives in the middle of any transfer, including a repeated START, resets the bit counter and returns the target to address reception. The partial byte is not stored.
- R9: A pulse on SCL or SDA shorter than FILT_LEN system clocks has no effect on the protocol.
- R10: The status inputs are captured at the start of each read byte. A change during the byte appears only in the next byte.
- R11: After reset, SDA is released and all configuration registers are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low power-on reset |
| scl_i | input | 1 | Sampled SCL line |
| sda_i | input | 1 | Sampled SDA line |
| sda_oe | output | 1 | Pull SDA low when 1 |
| strap_a0 | input | 1 | Strap; when high, clears address bit 0 |
| strap_a3 | input | 1 | Strap; when high, sets address bit 3 |
| st_afc_win | input | 1 | VCO inside AFC window |
| st_if_high | input | 1 | IF input level high |
| st_carrier | input | 1 | FM carrier detected |
| st_afc | input | 4 | AFC value |
| cfg_regs | output | NUM_REGS*8 | Configuration register bank, register i at bits 8i+7:8i |

## Verification
The bench walks all four strap settings and a foreign address. A wrong address decode would acknowledge the wrong chip or stay silent, and a leaky reject path would corrupt registers. The bench also sends a write whose pointer wraps past the last register, which catches a pointer that saturates or fails to step. Reads check that the power-on flag is 1 only in the first byte and that status inputs which toggle mid-byte appear only in the next byte. A target that captured the flag late or shifted live inputs would return a byte that mixes old and new values. Further tests cover a repeated START in the middle of a byte and single-clock glitches on SCL and on SDA while SCL is high. Without those protections the bit count would slip or a false STOP would abort the write.

// File: rtl/strap_i2c_pkg.sv
package strap_i2c_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK
  } tgt_state_e;

  // Device address from the two board straps.
  function automatic logic [6:0] strap_dev_addr(input logic s_a0, input logic s_a3);
    return {3'b100, s_a3, 2'b01, ~s_a0};
  endfunction

  // Status byte assembly, MSB first.
  function automatic logic [7:0] status_pack(input logic win, input logic lvl,
                                             input logic car, input logic [3:0] afc,
                                             input logic por);
    return {win, lvl, car, afc, por};
  endfunction

endpackage

// File: rtl/line_filter.sv
module line_filter #(
  parameter int FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  output logic clean
);
  localparam int CW = $clog2(FILT_LEN + 1);

  logic          s1, s2;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1    <= 1'b1;
      s2    <= 1'b1;
      clean <= 1'b1;
      cnt   <= '0;
    end else begin
      s1 <= raw;
      s2 <= s1;
      if (s2 == clean) begin
        cnt <= '0;
      end else if (cnt == CW'(FILT_LEN - 1)) begin
        clean <= s2;
        cnt   <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank #(
  parameter int NUM_REGS = 4,
  parameter int REG_W    = 8,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      set_ptr,
  input  logic                      wr_en,
  input  logic [REG_W-1:0]          din,
  output logic [IDX_W-1:0]          ptr,
  output logic [NUM_REGS*REG_W-1:0] regs
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       ptr <= '0;
    else if (set_ptr) ptr <= din[IDX_W-1:0];
    else if (wr_en)   ptr <= ptr + 1'b1;
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  regs[i*REG_W +: REG_W] <= '0;
      else if (wr_en && ptr == IDX_W'(i))          regs[i*REG_W +: REG_W] <= din;
    end
  end
endmodule

// File: rtl/strap_i2c_target.sv
module strap_i2c_target
  import strap_i2c_pkg::*;
#(
  parameter int FILT_LEN = 3,
  parameter int NUM_REGS = 4,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  scl_i,
  input  logic                  sda_i,
  output logic                  sda_oe,
  input  logic                  strap_a0,
  input  logic                  strap_a3,
  input  logic                  st_afc_win,
  input  logic                  st_if_high,
  input  logic                  st_carrier,
  input  logic [3:0]            st_afc,
  output logic [NUM_REGS*8-1:0] cfg_regs
);
  logic scl_f, sda_f, scl_q, sda_q;

  line_filter #(.FILT_LEN(FILT_LEN)) u_scl_flt (.clk(clk), .rst_n(rst_n), .raw(scl_i), .clean(scl_f));
  line_filter #(.FILT_LEN(FILT_LEN)) u_sda_flt (.clk(clk), .rst_n(rst_n), .raw(sda_i), .clean(sda_f));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_f;
      sda_q <= sda_f;
    end
  end

  // Named bus events
  logic scl_rise, scl_fall, start_evt, stop_evt;
  assign scl_rise  = scl_f & ~scl_q;
  assign scl_fall  = ~scl_f & scl_q;
  assign start_evt = scl_f & scl_q & sda_q & ~sda_f;
  assign stop_evt  = scl_f & scl_q & ~sda_q & sda_f;

  tgt_state_e       state;
  logic [7:0]       rx, tx;
  logic [3:0]       bitcnt;
  logic             rw, first_byte, mack, por_flag;
  logic [6:0]       my_addr;
  logic [IDX_W-1:0] ptr;

  assign my_addr = strap_dev_addr(strap_a0, strap_a3);

  // Named protocol events
  logic addr_done, addr_hit, wr_done, set_ptr, wr_en, rd_done, rd_load;
  assign addr_done = (state == ST_ADDR) && scl_fall && (bitcnt == 4'd8);
  assign addr_hit  = addr_done && (rx[7:1] == my_addr);
  assign wr_done   = (state == ST_WR) && scl_fall && (bitcnt == 4'd8);
  assign set_ptr   = wr_done && first_byte;
  assign wr_en     = wr_done && !first_byte;
  assign rd_done   = (state == ST_RACK) && scl_rise;
  assign rd_load   = scl_fall && (((state == ST_AACK) && rw) || ((state == ST_RACK) && mack));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      rx         <= '0;
      bitcnt     <= '0;
      rw         <= 1'b0;
      first_byte <= 1'b0;
      mack       <= 1'b0;
    end else if (stop_evt) begin
      state <= ST_IDLE;
    end else if (start_evt) begin
      state  <= ST_ADDR;
      bitcnt <= '0;
    end else begin
      unique case (state)
        ST_ADDR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            rx     <= {rx[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end
          if (addr_done) begin
            state <= addr_hit ? ST_AACK : ST_IDLE;
            rw    <= rx[0];
          end
        end
        ST_AACK: if (scl_fall) begin
          state      <= rw ? ST_RD : ST_WR;
          bitcnt     <= '0;
          first_byte <= 1'b1;
        end
        ST_WR: begin
          if (scl_rise && bitcnt < 4'd8) begin
            rx     <= {rx[6:0], sda_f};
            bitcnt <= bitcnt + 4'd1;
          end
          if (wr_done) state <= ST_WACK;
        end
        ST_WACK: if (scl_fall) begin
          state      <= ST_WR;
          bitcnt     <= '0;
          first_byte <= 1'b0;
        end
        ST_RD: if (scl_fall) begin
          if (bitcnt == 4'd7) state <= ST_RACK;
          else                bitcnt <= bitcnt + 4'd1;
        end
        ST_RACK: begin
          if (scl_rise) mack <= ~sda_f;
          if (scl_fall) begin
            state  <= mack ? ST_RD : ST_IDLE;
            bitcnt <= '0;
          end
        end
        default: ;
      endcase
    end
  end

  // Transmit shadow: captured once per read byte, then only shifted
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      tx <= 8'hFF;
    else if (rd_load)
      tx <= status_pack(st_afc_win, st_if_high, st_carrier, st_afc, por_flag);
    else if (state == ST_RD && scl_fall && bitcnt != 4'd7)
      tx <= {tx[6:0], 1'b1};
  end

  // Sticky power-on flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       por_flag <= 1'b1;
    else if (rd_done) por_flag <= 1'b0;
  end

  assign sda_oe = (state == ST_AACK) || (state == ST_WACK) || ((state == ST_RD) && !tx[7]);

  cfg_bank #(.NUM_REGS(NUM_REGS), .REG_W(8)) u_bank (
    .clk(clk), .rst_n(rst_n), .set_ptr(set_ptr), .wr_en(wr_en),
    .din(rx), .ptr(ptr), .regs(cfg_regs)
  );
endmodule

// File: rtl/strap_i2c_chk.sv
module strap_i2c_chk
  import strap_i2c_pkg::*;
#(
  parameter int IDX_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input tgt_state_e       state,
  input logic             scl_fall,
  input logic             start_evt,
  input logic             addr_done,
  input logic             addr_hit,
  input logic             rd_done,
  input logic             rd_load,
  input logic             mack,
  input logic             por_flag,
  input logic             sda_oe,
  input logic             wr_en,
  input logic [IDX_W-1:0] ptr,
  input logic [3:0]       bitcnt,
  input logic [7:0]       tx
);
  AST_ADDR_ACK: assert property (@(posedge clk) disable iff (!rst_n) addr_hit |=> sda_oe); // R4
  AST_FOREIGN_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (addr_done && !addr_hit) |=> !sda_oe); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n) wr_en |=> ptr == $past(ptr) + 1'b1); // R3
  AST_NACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RACK && scl_fall && !mack) |=> !sda_oe); // R6
  AST_POR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) rd_done |=> !por_flag); // R7
  AST_POR_STICKY: assert property (@(posedge clk) disable iff (!rst_n) !por_flag |=> !por_flag); // R7
  AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n) start_evt |=> (state == ST_ADDR && bitcnt == 4'd0)); // R8
  AST_TX_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (state == ST_RD && !scl_fall && !rd_load) |=> $stable(tx)); // R10
endmodule

bind strap_i2c_target strap_i2c_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(state), .scl_fall(scl_fall), .start_evt(start_evt),
  .addr_done(addr_done), .addr_hit(addr_hit), .rd_done(rd_done), .rd_load(rd_load),
  .mack(mack), .por_flag(por_flag), .sda_oe(sda_oe), .wr_en(wr_en), .ptr(ptr),
  .bitcnt(bitcnt), .tx(tx)
);

// File: tb/tb_strap_i2c_target.sv
module tb_strap_i2c_target;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 12;
  localparam int NREG       = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic strap_a0 = 1'b0, strap_a3 = 1'b0;
  logic win = 1'b0, lvl = 1'b0, car = 1'b0;
  logic [3:0] afc = 4'h0;
  logic sda_oe, sda_line;
  logic [NREG*8-1:0] cfg;

  int checks = 0, errors = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] obs;
  event       obs_ev;

  always #(CLK_PERIOD/2) clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  strap_i2c_target #(.FILT_LEN(3), .NUM_REGS(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .strap_a0(strap_a0), .strap_a3(strap_a3), .st_afc_win(win), .st_if_high(lvl),
    .st_carrier(car), .st_afc(afc), .cfg_regs(cfg)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Monitor: compares read bytes against the scoreboard queue
  initial forever begin
    @(obs_ev);
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R5: actual %h expected <none>", obs);
    end else begin
      automatic logic [7:0] e = exp_q.pop_front();
      automatic string      t = tag_q.pop_front();
      if (obs !== e) begin
        errors++;
        $display("FAIL %s: actual %h expected %h", t, obs, e);
      end
    end
  end

  task automatic wq(); repeat (Q) @(negedge clk); endtask

  task automatic send_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic send_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  // One clock; glitch=1 adds a 1-clock SDA pulse while SCL high and a 1-clock SCL pulse while low
  task automatic bit_io(input logic b, input bit glitch, output logic smp);
    sda_m = b; wq(); scl_m = 1'b1; wq(); smp = sda_line;
    if (glitch && !b) begin sda_m = 1'b1; @(negedge clk); sda_m = 1'b0; end
    wq(); scl_m = 1'b0;
    if (glitch) begin @(negedge clk); scl_m = 1'b1; @(negedge clk); scl_m = 1'b0; end
    wq();
  endtask

  task automatic wbyte(input logic [7:0] d, input bit glitch, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) bit_io(d[i], glitch, s);
    bit_io(1'b1, 1'b0, s);
    ack = ~s;
  endtask

  task automatic rbyte(input string tag, input logic [7:0] e, input logic nack, input bit flip);
    logic s;
    logic [7:0] d;
    exp_q.push_back(e); tag_q.push_back(tag);
    for (int i = 7; i >= 0; i--) begin
      bit_io(1'b1, 1'b0, s);
      d[i] = s;
      if (flip && i == 5) begin win = 1'b0; lvl = 1'b1; car = 1'b0; afc = 4'b0101; end
    end
    bit_io(nack, 1'b0, s);
    obs = d;
    ->obs_ev;
  endtask

  initial begin
    repeat (300000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic ack;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R11 sda released", {31'd0, sda_oe}, 32'd0);
    chk("R11 regs zero", cfg, 32'h0);

    // R1: all four strap settings
    for (int k = 0; k < 4; k++) begin
      automatic logic [6:0] a;
      strap_a0 = k[0]; strap_a3 = k[1];
      a = {3'b100, strap_a3, 2'b01, ~strap_a0};
      send_start(); wbyte({a, 1'b0}, 1'b0, ack); send_stop();
      chk("R1 strap address ack", {31'd0, ack}, 32'd1);
    end
    strap_a0 = 1'b0; strap_a3 = 1'b0;                  // address 0x43
    send_start(); wbyte({7'h4B, 1'b0}, 1'b0, ack); send_stop();
    chk("R2 foreign address nack", {31'd0, ack}, 32'd0);

    // R3/R4: pointer load, auto-increment and wrap
    send_start();
    wbyte(8'h86, 1'b0, ack); chk("R4 address ack", {31'd0, ack}, 32'd1);
    wbyte(8'h01, 1'b0, ack); chk("R4 index ack", {31'd0, ack}, 32'd1);
    wbyte(8'hA5, 1'b0, ack);
    wbyte(8'h3C, 1'b0, ack);
    wbyte(8'h7E, 1'b0, ack);
    wbyte(8'h11, 1'b0, ack); chk("R4 data ack", {31'd0, ack}, 32'd1);
    send_stop();
    chk("R3 write with wrap", cfg, 32'h7E3CA511);

    // R2: rejected address then data
    send_start();
    wbyte(8'h84, 1'b0, ack); chk("R2 mismatch nack", {31'd0, ack}, 32'd0);
    wbyte(8'h00, 1'b0, ack);
    wbyte(8'hFF, 1'b0, ack); chk("R2 later byte nack", {31'd0, ack}, 32'd0);
    send_stop();
    chk("R2 regs unchanged", cfg, 32'h7E3CA511);

    // R5/R6/R7: status layout, continuation, power-on flag clearing
    win = 1'b1; lvl = 1'b0; car = 1'b1; afc = 4'b1010;
    send_start();
    wbyte(8'h87, 1'b0, ack); chk("R4 read address ack", {31'd0, ack}, 32'd1);
    rbyte("R7 first byte power-on flag set", 8'hB5, 1'b0, 1'b0);
    rbyte("R7 flag cleared after read", 8'hB4, 1'b0, 1'b0);
    rbyte("R6 read continues on ack", 8'hB4, 1'b1, 1'b0);
    chk("R6 released after nack", {31'd0, sda_oe}, 32'd0);
    send_stop();
    chk("R6 released after stop", {31'd0, sda_oe}, 32'd0);

    // R10: inputs change mid-byte
    send_start();
    wbyte(8'h87, 1'b0, ack);
    rbyte("R10 byte held while shifting", 8'hB4, 1'b0, 1'b1);
    rbyte("R10 next byte takes new status", 8'h4A, 1'b1, 1'b0);
    send_stop();

    // R8: repeated START mid-byte
    send_start();
    wbyte(8'h86, 1'b0, ack);
    begin
      logic s;
      bit_io(1'b1, 1'b0, s); bit_io(1'b0, 1'b0, s); bit_io(1'b1, 1'b0, s);
    end
    send_start();
    wbyte(8'h87, 1'b0, ack); chk("R8 address after repeated start", {31'd0, ack}, 32'd1);
    rbyte("R8 read after repeated start", 8'h4A, 1'b1, 1'b0);
    send_stop();
    chk("R8 partial byte not stored", cfg, 32'h7E3CA511);

    // R9: glitches on both lines during a write
    send_start();
    wbyte(8'h86, 1'b0, ack);
    wbyte(8'h02, 1'b0, ack);
    wbyte(8'h5A, 1'b1, ack); chk("R9 glitched byte ack", {31'd0, ack}, 32'd1);
    send_stop();
    chk("R9 glitches ignored", cfg, 32'h7E5AA511);

    repeat (20) @(negedge clk);
    chk("R6 scoreboard drained", exp_q.size(), 32'd0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule